// File: doc/BRIEF.md
# Instruction Cycle Arbiter

The arbiter is a two-bit phase machine that steps a small processor through its instruction cycle. It has four phases: halted, fetching, executing, and negotiating an interrupt with a peripheral. The phase moves forward only when a completion strobe arrives for the phase the machine is in. Those strobes are end of fetch, end of execute, end of interrupt, and a start pulse from the operator panel. All strobes are active low, one clock wide, and synchronous to the system clock. The state register uses them as a clock enable. It never runs freely.

The block also holds the halt flag. A HALT button pulse sets it, a RUN pulse clears it, and a STEP pulse clears it only for one instruction. The halt flag and the active-low interrupt request are looked at only when an execute cycle ends, so an instruction is never dropped halfway. The fetch sequencer, the execute units and the interrupt controller each get one decoded enable, and a halted indicator is provided as well.

Phases (`phase[1:0]`): PH_HALT = 00, PH_FETCH = 01, PH_EXEC = 10, PH_INTR = 11. Transitions:
- HALT→FETCH on `go_n`.
- FETCH→EXEC on `fetch_done_n`.
- EXEC→FETCH, EXEC→HALT or EXEC→INTR on `exec_done_n`.
- INTR→FETCH on `intr_done_n`.

Top module: `cyc_arbiter`

## Requirements
- R1: While `rst_n` is low and after it is released, `phase` is 00 (halted), and the halt flag is set when the parameter HALT_AT_RESET is 1.
- R2: `phase` changes only on a clock edge where a strobe matching the current phase is low; on every other edge it holds.
- R3: In phase 00, a low `go_n` moves the phase to 01 on the next edge.
- R4: In phase 01, a low `fetch_done_n` moves the phase to 10.
- R5: In phase 10, a low `exec_done_n` with the halt flag clear and `irq_n` high moves the phase to 01.
- R6: In phase 10, a low `exec_done_n` with the halt flag set moves the phase to 00. This holds even if `irq_n` is low, because halt has priority.
- R7: In phase 10, a low `exec_done_n` with the halt flag clear and `irq_n` low moves the phase to 11.
- R8: In phase 11, a low `intr_done_n` moves the phase to 01.
- R9: `irq_n` and the halt flag have no effect on any transition other than the one from phase 10 on `exec_done_n`.
- R10: A strobe that does not belong to the current phase leaves the phase unchanged.
- R11: Button pulses act on the halt flag as follows.
  - `btn_halt` sets the flag.
  - `btn_run` clears it.
  - `btn_step` clears it and sets it again at the next end of execute, so exactly one instruction runs.
  - If pulses coincide, halt wins over step, and step wins over run.
- R12: Exactly one of `is_halted`, `fetch_en`, `exec_en` and `intr_en` is high, and it matches `phase`: 00, 01, 10 or 11 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_n | input | 1 | Start pulse from the operator panel, active low |
| fetch_done_n | input | 1 | End-of-fetch strobe, active low |
| exec_done_n | input | 1 | End-of-execute strobe, active low |
| intr_done_n | input | 1 | End-of-interrupt strobe, active low |
| irq_n | input | 1 | Pending interrupt request, active low |
| btn_halt | input | 1 | HALT button pulse, sets the halt flag |
| btn_run | input | 1 | RUN button pulse, clears the halt flag |
| btn_step | input | 1 | STEP button pulse, runs one instruction |
| phase | output | 2 | Current phase: 00 halt, 01 fetch, 10 execute, 11 interrupt |
| is_halted | output | 1 | High in phase 00 |
| fetch_en | output | 1 | Fetch sequencer enable, high in phase 01 |
| exec_en | output | 1 | Execute unit enable, high in phase 10 |
| intr_en | output | 1 | Interrupt controller enable, high in phase 11 |

## Verification
The bench builds the arbiter with the default HALT_AT_RESET = 1, so the machine leaves reset halted with the flag set. This setting makes the full operator path reachable: a start pulse before RUN ends the first instruction back in halt, a STEP runs exactly one instruction, and RUN then opens continuous cycling. With the flag cleared, an interrupt request that is held through fetch reaches the execute-end decision. It is then checked against a raised halt flag to confirm that halt has priority. Strobes that do not match the current phase are sent in every phase to show that they are ignored.

// File: rtl/cyc_arb_pkg.sv
`timescale 1ns/1ps
package cyc_arb_pkg;
    localparam int PH_W = 2;

    typedef enum logic [PH_W-1:0] {
        PH_HALT  = 2'b00,
        PH_FETCH = 2'b01,
        PH_EXEC  = 2'b10,
        PH_INTR  = 2'b11
    } phase_e;
endpackage

// File: rtl/cyc_halt_ctl.sv
`timescale 1ns/1ps
module cyc_halt_ctl #(
    parameter bit HALT_AT_RESET = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_halt,
    input  logic btn_run,
    input  logic btn_step,
    input  logic exec_end,
    output logic halt_eff
);
    logic halt_q;
    logic step_armed;

    // Halt beats step, step beats run; an armed step re-sets the flag at execute end.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            halt_q     <= HALT_AT_RESET;
            step_armed <= 1'b0;
        end else if (btn_halt) begin
            halt_q     <= 1'b1;
            step_armed <= 1'b0;
        end else if (btn_step) begin
            halt_q     <= 1'b0;
            step_armed <= 1'b1;
        end else if (btn_run) begin
            halt_q     <= 1'b0;
            step_armed <= 1'b0;
        end else if (exec_end && step_armed) begin
            halt_q     <= 1'b1;
            step_armed <= 1'b0;
        end
    end

    // An armed step already counts as halt for the end-of-execute decision.
    assign halt_eff = halt_q | step_armed;
endmodule

// File: rtl/cyc_next_phase.sv
`timescale 1ns/1ps
module cyc_next_phase
    import cyc_arb_pkg::*;
(
    input  phase_e cur,
    input  logic   go_n,
    input  logic   fetch_done_n,
    input  logic   exec_done_n,
    input  logic   intr_done_n,
    input  logic   halt_eff,
    input  logic   irq_n,
    output logic   advance,
    output phase_e nxt
);
    always_comb begin
        advance = 1'b0;
        nxt     = cur;
        unique case (cur)
            PH_HALT: begin
                advance = !go_n;
                nxt     = PH_FETCH;
            end
            PH_FETCH: begin
                advance = !fetch_done_n;
                nxt     = PH_EXEC;
            end
            PH_EXEC: begin
                advance = !exec_done_n;
                if (halt_eff)
                    nxt = PH_HALT;
                else if (!irq_n)
                    nxt = PH_INTR;
                else
                    nxt = PH_FETCH;
            end
            PH_INTR: begin
                advance = !intr_done_n;
                nxt     = PH_FETCH;
            end
        endcase
    end
endmodule

// File: rtl/cyc_phase_decode.sv
`timescale 1ns/1ps
module cyc_phase_decode
    import cyc_arb_pkg::*;
(
    input  phase_e cur,
    output logic   is_halted,
    output logic   fetch_en,
    output logic   exec_en,
    output logic   intr_en
);
    always_comb begin
        is_halted = 1'b0;
        fetch_en  = 1'b0;
        exec_en   = 1'b0;
        intr_en   = 1'b0;
        unique case (cur)
            PH_HALT:  is_halted = 1'b1;
            PH_FETCH: fetch_en  = 1'b1;
            PH_EXEC:  exec_en   = 1'b1;
            PH_INTR:  intr_en   = 1'b1;
        endcase
    end
endmodule

// File: rtl/cyc_arbiter.sv
`timescale 1ns/1ps
module cyc_arbiter
    import cyc_arb_pkg::*;
#(
    parameter bit HALT_AT_RESET = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go_n,
    input  logic            fetch_done_n,
    input  logic            exec_done_n,
    input  logic            intr_done_n,
    input  logic            irq_n,
    input  logic            btn_halt,
    input  logic            btn_run,
    input  logic            btn_step,
    output logic [PH_W-1:0] phase,
    output logic            is_halted,
    output logic            fetch_en,
    output logic            exec_en,
    output logic            intr_en
);
    phase_e cur_q;
    phase_e nxt;
    logic   advance;
    logic   halt_eff;
    logic   exec_end;

    assign exec_end = (cur_q == PH_EXEC) && !exec_done_n;

    cyc_halt_ctl #(.HALT_AT_RESET(HALT_AT_RESET)) u_halt (
        .clk      (clk),
        .rst_n    (rst_n),
        .btn_halt (btn_halt),
        .btn_run  (btn_run),
        .btn_step (btn_step),
        .exec_end (exec_end),
        .halt_eff (halt_eff)
    );

    cyc_next_phase u_next (
        .cur          (cur_q),
        .go_n         (go_n),
        .fetch_done_n (fetch_done_n),
        .exec_done_n  (exec_done_n),
        .intr_done_n  (intr_done_n),
        .halt_eff     (halt_eff),
        .irq_n        (irq_n),
        .advance      (advance),
        .nxt          (nxt)
    );

    // State register: a matching strobe acts as the clock enable.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cur_q <= PH_HALT;
        else if (advance)
            cur_q <= nxt;
    end

    cyc_phase_decode u_dec (
        .cur       (cur_q),
        .is_halted (is_halted),
        .fetch_en  (fetch_en),
        .exec_en   (exec_en),
        .intr_en   (intr_en)
    );

    assign phase = cur_q;
endmodule

// File: rtl/cyc_arbiter_chk.sv
`timescale 1ns/1ps
module cyc_arbiter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       go_n,
    input logic       fetch_done_n,
    input logic       exec_done_n,
    input logic       intr_done_n,
    input logic       irq_n,
    input logic       halt_eff,
    input logic [1:0] phase,
    input logic       is_halted,
    input logic       fetch_en,
    input logic       exec_en,
    input logic       intr_en
);
    a_r2_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (go_n && fetch_done_n && exec_done_n && intr_done_n) |=> $stable(phase));

    a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b00 && !go_n) |=> phase == 2'b01);

    a_r4_fetch_end: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b01 && !fetch_done_n) |=> phase == 2'b10);

    a_r5_exec_to_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b10 && !exec_done_n && !halt_eff && irq_n) |=> phase == 2'b01);

    a_r6_exec_to_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b10 && !exec_done_n && halt_eff) |=> phase == 2'b00);

    a_r7_exec_to_intr: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b10 && !exec_done_n && !halt_eff && !irq_n) |=> phase == 2'b11);

    a_r8_intr_end: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b11 && !intr_done_n) |=> phase == 2'b01);

    a_r10_foreign_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b10 && exec_done_n) |=> phase == 2'b10);

    a_r12_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({is_halted, fetch_en, exec_en, intr_en}) == 1);
endmodule

bind cyc_arbiter cyc_arbiter_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .go_n         (go_n),
    .fetch_done_n (fetch_done_n),
    .exec_done_n  (exec_done_n),
    .intr_done_n  (intr_done_n),
    .irq_n        (irq_n),
    .halt_eff     (halt_eff),
    .phase        (phase),
    .is_halted    (is_halted),
    .fetch_en     (fetch_en),
    .exec_en      (exec_en),
    .intr_en      (intr_en)
);

// File: tb/test_cyc_arbiter.sv
`timescale 1ns/1ps
module test_cyc_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       go_n = 1'b1, fetch_done_n = 1'b1, exec_done_n = 1'b1, intr_done_n = 1'b1;
    logic       irq_n = 1'b1;
    logic       btn_halt = 1'b0, btn_run = 1'b0, btn_step = 1'b0;
    logic [1:0] phase;
    logic       is_halted, fetch_en, exec_en, intr_en;

    int  checks = 0;
    int  errors = 0;
    bit  ended  = 1'b0;

    always #2.5 clk = ~clk;

    cyc_arbiter #(.HALT_AT_RESET(1'b1)) i_cyc_arbiter (
        .clk(clk), .rst_n(rst_n), .go_n(go_n), .fetch_done_n(fetch_done_n),
        .exec_done_n(exec_done_n), .intr_done_n(intr_done_n), .irq_n(irq_n),
        .btn_halt(btn_halt), .btn_run(btn_run), .btn_step(btn_step),
        .phase(phase), .is_halted(is_halted), .fetch_en(fetch_en),
        .exec_en(exec_en), .intr_en(intr_en)
    );

    // Phase plus the decoded enables (R12) against the expected phase.
    task automatic expect_phase(input string req, input logic [1:0] exp);
        logic [3:0] got_dec, exp_dec;
        got_dec = {intr_en, exec_en, fetch_en, is_halted};
        exp_dec = 4'b0001 << exp;
        checks++;
        if (phase !== exp) begin
            errors++;
            $display("FAIL %s: phase=%b expected %b", req, phase, exp);
        end
        checks++;
        if (got_dec !== exp_dec) begin
            errors++;
            $display("FAIL R12 (%s): enables=%b expected %b", req, got_dec, exp_dec);
        end
    endtask

    // Strobe codes: 0 start, 1 end of fetch, 2 end of execute, 3 end of interrupt.
    task automatic strobe(input int which);
        @(negedge clk);
        case (which)
            0: go_n = 1'b0;
            1: fetch_done_n = 1'b0;
            2: exec_done_n = 1'b0;
            default: intr_done_n = 1'b0;
        endcase
        @(negedge clk);
        go_n = 1'b1; fetch_done_n = 1'b1; exec_done_n = 1'b1; intr_done_n = 1'b1;
    endtask

    // Button codes: 0 halt, 1 run, 2 step.
    task automatic press(input int which);
        @(negedge clk);
        case (which)
            0: btn_halt = 1'b1;
            1: btn_run = 1'b1;
            default: btn_step = 1'b1;
        endcase
        @(negedge clk);
        btn_halt = 1'b0; btn_run = 1'b0; btn_step = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        expect_phase("R1 in reset", 2'b00);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        expect_phase("R2 idle after reset", 2'b00);
    endtask

    task automatic t_flag_from_reset();
        // The flag is set at reset, so one instruction ends back in halt (R1, R6).
        strobe(0); expect_phase("R3 start", 2'b01);
        strobe(1); expect_phase("R4 fetch end", 2'b10);
        strobe(2); expect_phase("R1 reset flag halts", 2'b00);
    endtask

    task automatic t_step();
        press(2);
        expect_phase("R11 step alone holds", 2'b00);
        strobe(0); expect_phase("R11 step start", 2'b01);
        strobe(1); expect_phase("R11 step fetch", 2'b10);
        strobe(2); expect_phase("R11 step one instruction", 2'b00);
        strobe(0); strobe(1); strobe(2);
        expect_phase("R11 flag re-set after step", 2'b00);
    endtask

    task automatic t_run_loop();
        press(1);
        expect_phase("R2 run alone holds", 2'b00);
        strobe(0); expect_phase("R3 start after run", 2'b01);
        strobe(2); expect_phase("R10 exec end in fetch", 2'b01);
        strobe(3); expect_phase("R10 intr end in fetch", 2'b01);
        strobe(0); expect_phase("R10 start in fetch", 2'b01);
        strobe(1); expect_phase("R4 fetch end", 2'b10);
        strobe(1); expect_phase("R10 fetch end in exec", 2'b10);
        strobe(2); expect_phase("R5 exec to fetch", 2'b01);
    endtask

    task automatic t_interrupt();
        @(negedge clk); irq_n = 1'b0;
        strobe(1); expect_phase("R9 irq ignored at fetch end", 2'b10);
        strobe(2); expect_phase("R7 exec to intr", 2'b11);
        strobe(0); expect_phase("R10 start in intr", 2'b11);
        @(negedge clk); irq_n = 1'b1;
        strobe(3); expect_phase("R8 intr end", 2'b01);
    endtask

    task automatic t_halt_priority();
        press(0);
        expect_phase("R9 halt ignored in fetch", 2'b01);
        @(negedge clk); irq_n = 1'b0;
        strobe(1); expect_phase("R9 halt ignored at fetch end", 2'b10);
        strobe(2); expect_phase("R6 halt beats irq", 2'b00);
        @(negedge clk); irq_n = 1'b1;
        strobe(3); expect_phase("R10 intr end in halt", 2'b00);
    endtask

    task automatic t_button_priority();
        // Step and run together: step wins, so one instruction then halt (R11).
        @(negedge clk); btn_step = 1'b1; btn_run = 1'b1;
        @(negedge clk); btn_step = 1'b0; btn_run = 1'b0;
        strobe(0); strobe(1); strobe(2);
        expect_phase("R11 step beats run", 2'b00);
        press(1);
        strobe(0); strobe(1); strobe(2);
        expect_phase("R11 run keeps cycling", 2'b01);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_flag_from_reset();
        t_step();
        t_run_loop();
        t_interrupt();
        t_halt_priority();
        t_button_priority();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end, actual timeout expected completion");
        finish_run();
    end
endmodule